// File: doc/BRIEF.md
# Start-Pattern Detector with Bit-Clock Recovery

This block takes a sliced serial data line that has no timing relation to the system clock and brings it into the system clock domain. It samples each bit sixteen times and watches the recovered bit stream for a fixed 16-bit start word. Until that word arrives, the data output simply follows the line. Once the word is seen, the block produces a bit clock at the selected bit rate and a retimed data bit that a host can latch on the falling edge of that clock.

The recovery stays engaged until the host clears the enable. Searching begins again only after the enable is set once more. The host picks one of nine standard bit rates with a 4-bit code. The dividers for each rate are worked out at elaboration from the system clock frequency, which is a parameter.

Top module: `startpat_clkrec`

## Requirements
- R1: While enabled and searching, every newly recovered bit is shifted into a 16-bit window, with the oldest bit at the most significant position. The block arms as soon as the window equals 0xE2E2, the word having been sent most significant bit first. A near miss such as 0xE2E3 does not arm it.
- R2: While disabled, or while enabled but not yet armed, `data_o` equals `rx_raw_i` delayed by three clock cycles: two synchronizer stages and one output register.
- R3: After arming, `data_o` carries the recovered bits. The first of them is the bit that immediately follows the start word.
- R4: `rclk_o` is low whenever the enable is clear, and while enabled before the start word has been found.
- R5: Each recovered bit appears on `data_o` in the same cycle that `rclk_o` rises, and it holds unchanged for as long as `rclk_o` stays high.
- R6: With D = max(1, floor(CLK_HZ / (16 x bit rate))), a steady line gives `rclk_o` high for 8·D cycles and then low for 8·D cycles, which is a period of 16·D cycles. The rise comes two cycles after the centre sample of a bit.
- R7: `rate_i` codes 0 through 8 select 1200, 2400, 4800, 9600, 19200, 38400, 57600, 115200 and 230400 bit/s, in that order.
- R8: Codes 9 through 15 select the same divider as 1200 bit/s.
- R9: Once armed, clocking goes on (following the held line level if no more edges come) until `en_i` is sampled low. On the first edge where it is low, `rclk_o` goes low and `data_o` goes back to the synchronized line.
- R10: A start word sent while the enable is low is ignored. Arming again needs the enable to be set back to 1, after which a new start word is required.
- R11: Each bit is sampled at its centre (the 8th of 16 sub-bit ticks). The sub-bit phase is re-centred on every line transition, so bit lengths that jitter by less than a quarter bit are still recovered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_raw_i | input | 1 | Asynchronous sliced receive data |
| en_i | input | 1 | Recovery enable; a rising level starts a new search |
| rate_i | input | RATE_W | Bit-rate select code |
| data_o | output | 1 | Line data before arming, recovered bits after |
| rclk_o | output | 1 | Recovered bit clock, low while not armed |

## Verification
A change on the line reaches `data_o` on the third rising edge while unarmed. Clearing the enable takes effect on the very next edge. A recovered bit shows up together with the `rclk_o` rise, two edges after its centre sample. The bench drives inputs just after falling edges and samples one full cycle later, so each of these latencies is checked in exactly the cycle it is due. For recovered bits and clock timing, a monitor on the falling edge records every `rclk_o` rise, the data seen there, and the high and period lengths in cycles. Those records are compared with a bench model that finds the first start-word match in the driven bit sequence and computes the divider from the rate table.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_HUNT = 2'd1,
    M_LOCK = 2'd2
  } mode_t;

  // Bit rate for a select code; codes past the table fall back to the slowest rate.
  function automatic int unsigned rate_bps(input int code);
    case (code)
      0:       return 1200;
      1:       return 2400;
      2:       return 4800;
      3:       return 9600;
      4:       return 19200;
      5:       return 38400;
      6:       return 57600;
      7:       return 115200;
      8:       return 230400;
      default: return 1200;
    endcase
  endfunction

  // System clocks per oversampling tick, never below one.
  function automatic int unsigned rate_div(input longint unsigned clk_hz,
                                           input int unsigned ovs,
                                           input int code);
    longint unsigned d;
    d = clk_hz / (longint'(rate_bps(code)) * longint'(ovs));
    if (d < 1) d = 1;
    return int'(d);
  endfunction

endpackage

// File: rtl/scr_sync.sv
`timescale 1ns/1ps
module scr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i) begin
    ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scr_bit_timer.sv
`timescale 1ns/1ps
module scr_bit_timer #(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned OVS    = 16,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              din_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              bit_vld_o,
  output logic              bit_val_o,
  output logic              bit_end_o
);
  localparam int unsigned DIV_MAX = scr_pkg::rate_div(CLK_HZ, OVS, 0);
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);
  localparam int unsigned PH_W    = $clog2(OVS);
  localparam int unsigned N_CODES = 1 << RATE_W;
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [DIV_W-1:0] div_tab [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_div
    assign div_tab[g] = DIV_W'(scr_pkg::rate_div(CLK_HZ, OVS, g));
  end

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pre_q;
  logic [PH_W-1:0]  ph_q;
  logic             last_q;
  logic             edge_w;
  logic             tick_w;

  assign edge_w = din_i ^ last_q;
  assign tick_w = (pre_q >= div_q - DIV_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q     <= div_tab[0];
      pre_q     <= '0;
      ph_q      <= '0;
      last_q    <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_val_o <= 1'b0;
      bit_end_o <= 1'b0;
    end else begin
      div_q     <= div_tab[rate_i];
      last_q    <= din_i;
      bit_vld_o <= 1'b0;
      bit_end_o <= 1'b0;
      if (edge_w) begin
        pre_q     <= '0;
        ph_q      <= '0;
        bit_end_o <= 1'b1;
      end else if (tick_w) begin
        pre_q <= '0;
        ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
        if (ph_q == PH_MID) begin
          bit_vld_o <= 1'b1;
          bit_val_o <= din_i;
        end
        if (ph_q == PH_LAST) bit_end_o <= 1'b1;
      end else begin
        pre_q <= pre_q + DIV_W'(1);
      end
    end
  end

  // R6: a centre strobe and a bit-end strobe never coincide
  a_r6_centre_end_apart: assert property (@(posedge clk_i) disable iff (rst_i)
    !(bit_vld_o && bit_end_o));

  // R11: the phase counter never runs past the oversampling count
  a_r11_phase_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(ph_q) == PH_LAST && !$past(edge_w) && $past(tick_w)) |-> ph_q == '0);
endmodule

// File: rtl/scr_lock_ctrl.sv
`timescale 1ns/1ps
module scr_lock_ctrl #(
  parameter int unsigned      PAT_W   = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hE2E2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          din_i,
  input  logic          bit_vld_i,
  input  logic          bit_val_i,
  input  logic          bit_end_i,
  output logic          data_o,
  output logic          rclk_o,
  output scr_pkg::mode_t mode_o
);
  import scr_pkg::*;

  mode_t            mode_q;
  logic [PAT_W-1:0] win_q;
  logic [PAT_W-1:0] win_nx;
  logic             hit_w;

  assign win_nx = {win_q[PAT_W-2:0], bit_val_i};
  assign hit_w  = bit_vld_i && (win_nx == PATTERN);
  assign mode_o = mode_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q <= '0;
    end else if (bit_vld_i) begin
      win_q <= win_nx;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= M_OFF;
    end else if (!en_i) begin
      mode_q <= M_OFF;
    end else begin
      case (mode_q)
        M_OFF:   mode_q <= M_HUNT;
        M_HUNT:  if (hit_w) mode_q <= M_LOCK;
        default: mode_q <= M_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o <= 1'b0;
      rclk_o <= 1'b0;
    end else if (!en_i || mode_q != M_LOCK) begin
      data_o <= din_i;
      rclk_o <= 1'b0;
    end else if (bit_vld_i) begin
      data_o <= bit_val_i;
      rclk_o <= 1'b1;
    end else if (bit_end_i) begin
      rclk_o <= 1'b0;
    end
  end

  // R4: no clock while unarmed
  a_r4_rclk_low_unlocked: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q != M_LOCK) |-> !rclk_o);

  // R5: data held while the clock is high
  a_r5_data_stable_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (rclk_o && $past(rclk_o)) |-> $stable(data_o));

  // R1: arming only follows a recovered bit while enabled
  a_r1_lock_on_bit: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q == M_LOCK && $past(mode_q) != M_LOCK) |-> $past(bit_vld_i && en_i));

  // R9: armed state persists while enabled
  a_r9_lock_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(mode_q) == M_LOCK && $past(en_i)) |-> mode_q == M_LOCK);

  // R10: no direct jump from disabled to armed
  a_r10_no_lock_from_off: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(mode_q) == M_OFF) |-> mode_q != M_LOCK);
endmodule

// File: rtl/startpat_clkrec.sv
`timescale 1ns/1ps
module startpat_clkrec #(
  parameter int unsigned      CLK_HZ      = 200_000_000,
  parameter int unsigned      OVS         = 16,
  parameter int unsigned      RATE_W      = 4,
  parameter int unsigned      PAT_W       = 16,
  parameter logic [PAT_W-1:0] PATTERN     = 16'hE2E2,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rx_raw_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              data_o,
  output logic              rclk_o
);
  logic           line_s;
  logic           bit_vld;
  logic           bit_val;
  logic           bit_end;
  scr_pkg::mode_t mode;

  scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (rx_raw_i),
    .q_o   (line_s)
  );

  scr_bit_timer #(.CLK_HZ(CLK_HZ), .OVS(OVS), .RATE_W(RATE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .din_i     (line_s),
    .rate_i    (rate_i),
    .bit_vld_o (bit_vld),
    .bit_val_o (bit_val),
    .bit_end_o (bit_end)
  );

  scr_lock_ctrl #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .din_i     (line_s),
    .bit_vld_i (bit_vld),
    .bit_val_i (bit_val),
    .bit_end_i (bit_end),
    .data_o    (data_o),
    .rclk_o    (rclk_o),
    .mode_o    (mode)
  );

  // Cycles since reset, so the passthrough check never reaches before it.
  logic [1:0] warm_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R2: unarmed output is the line delayed by three cycles
  a_r2_raw_passthru: assert property (@(posedge clk_i) disable iff (rst_i)
    (warm_q == 2'd3 && $past(!en_i || mode != scr_pkg::M_LOCK))
      |-> data_o == $past(rx_raw_i, 3));
endmodule

// File: tb/test_startpat_clkrec.sv
`timescale 1ns/1ps
module test_startpat_clkrec;
  localparam int unsigned CLK_HZ = 3_686_400;
  localparam logic [15:0] PAT = 16'hE2E2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw = 1'b0;
  logic       en  = 1'b0;
  logic [3:0] rate = 4'd7;
  logic       data_o;
  logic       rclk_o;

  always #2.5 clk = ~clk;

  startpat_clkrec #(.CLK_HZ(CLK_HZ)) i_startpat_clkrec (
    .clk_i    (clk),
    .rst_i    (rst),
    .rx_raw_i (raw),
    .en_i     (en),
    .rate_i   (rate),
    .data_o   (data_o),
    .rclk_o   (rclk_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_div(input int code);
    int unsigned bps;
    int unsigned d;
    case (code)
      0: bps = 1200;    1: bps = 2400;   2: bps = 4800;
      3: bps = 9600;    4: bps = 19200;  5: bps = 38400;
      6: bps = 57600;   7: bps = 115200; 8: bps = 230400;
      default: bps = 1200;
    endcase
    d = CLK_HZ / (bps * 16);
    return (d < 1) ? 1 : d;
  endfunction

  // Monitor of the recovered clock
  int   cyc = 0;
  logic cap [1024];
  int   cap_n = 0;
  int   rise_cyc = 0;
  int   per_len = 0;
  int   hi_len = 0;
  int   stab_bad = 0;
  logic held = 1'b0;
  logic prev = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rclk_o && !prev) begin
      if (cap_n < 1024) cap[cap_n] = data_o;
      cap_n++;
      per_len  = cyc - rise_cyc;
      rise_cyc = cyc;
      held     = data_o;
    end
    if (!rclk_o && prev) hi_len = cyc - rise_cyc;
    if (rclk_o && prev && data_o !== held) stab_bad++;
    prev = rclk_o;
  end

  task automatic send_bit(input logic b, input int len);
    raw = b;
    repeat (len) @(negedge clk);
  endtask

  task automatic flush();
    en   = 1'b0;
    rate = 4'd8;
    raw  = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  // Lock test: random preamble, start word, random message, optional jitter.
  task automatic run_lock(input int code, input int npre, input int nmsg, input int jit, input string rtag);
    logic bits [128];
    int len;
    int lk;
    int base;
    int t;
    int got;
    int exp_n;
    logic [15:0] w;
    flush();
    rate = code[3:0];
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    len = npre + 16 + nmsg;
    for (int i = 0; i < npre; i++) bits[i] = 1'($urandom_range(0, 1));
    for (int i = 0; i < 16; i++) bits[npre + i] = PAT[15 - i];
    for (int i = 0; i < nmsg; i++) bits[npre + 16 + i] = 1'($urandom_range(0, 1));
    w = '0;
    lk = -1;
    for (int k = 0; k < len; k++) begin
      w = {w[14:0], bits[k]};
      if (lk < 0 && w == PAT) lk = k;
    end
    t = 16 * exp_div(code);
    base = cap_n;
    for (int i = 0; i < len; i++) send_bit(bits[i], t + ((jit == 0) ? 0 : ((i % 2 == 0) ? jit : -jit)));
    repeat (3 * t) @(negedge clk);
    got = cap_n - base;
    exp_n = len - 1 - lk;
    check({"R9 clocking continues ", rtag}, 32'(got >= exp_n), 32'd1);
    for (int i = 0; i < exp_n; i++)
      check({"R3 recovered bit ", rtag}, 32'(cap[base + i]), 32'(bits[lk + 1 + i]));
    check({"R9 held level after stream ", rtag}, 32'(cap[cap_n - 1]), 32'(bits[len - 1]));
    check({"R6 high length ", rtag}, 32'(hi_len), 32'(8 * exp_div(code)));
    check({"R7 period ", rtag}, 32'(per_len), 32'(t));
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R9 clock low after clear", 32'(rclk_o), 32'd0);
    check("R9 line data after clear", 32'(data_o), 32'(raw));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd7741));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset clock", 32'(rclk_o), 32'd0);
    check("R2 reset data", 32'(data_o), 32'd0);

    // R2: three-cycle passthrough latency while disabled
    raw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 latency two cycles", 32'(data_o), 32'd0);
    @(negedge clk);
    check("R2 latency three cycles", 32'(data_o), 32'd1);
    raw = 1'b0;
    repeat (10) @(negedge clk);

    // R1, R4: near miss must not arm
    flush();
    rate = 4'd7;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    base = cap_n;
    for (int i = 15; i >= 0; i--) send_bit(16'hE2E3 >> i, 32);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 32);
    check("R1 near miss no clock", 32'(cap_n - base), 32'd0);
    check("R4 clock low while hunting", 32'(rclk_o), 32'd0);
    raw = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 passthrough while hunting", 32'(data_o), 32'd1);
    raw = 1'b0;
    repeat (64) @(negedge clk);

    run_lock(7, 8, 24, 0, "code7");

    // R10: start word while disabled is ignored
    flush();
    rate = 4'd7;
    repeat (4) @(negedge clk);
    base = cap_n;
    for (int i = 15; i >= 0; i--) send_bit(PAT[i], 32);
    for (int i = 0; i < 8; i++) send_bit(1'(i % 2), 32);
    check("R10 no clock while disabled", 32'(cap_n - base), 32'd0);
    check("R4 clock low while disabled", 32'(rclk_o), 32'd0);

    run_lock(8, 6, 20, 0, "code8 R10 re-enable");
    run_lock(3, 4, 12, 0, "code3");
    run_lock(4, 5, 16, 5, "code4 R11 jitter");
    run_lock(15, 0, 3, 0, "code15 R8 fallback");

    check("R5 data stable while clock high", 32'(stab_bad), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule